// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Status and Mask Unit

This block gathers the ready levels of two serial channels into a single interrupt status byte, combines that byte with a write-only enable mask, and drives one level-sensitive interrupt request towards the host. Each channel supplies a transmitter-ready level and a receive-ready level. The channel logic that produces these levels lies outside the block.

The host reaches both registers through one shared byte offset. A read at that offset returns the status byte. A write at that offset loads the mask byte. The mask therefore cannot be read back, and the host software keeps its own copy of it. Channel B uses the same bit layout as channel A, moved up by four bit positions. The host can tell which source raised the request by reading the status byte, and can enable sources one at a time through the mask.

The ready levels are sampled into a status register on every clock. The request output is formed from the status and mask registers, so it follows a change at the channel inputs after one clock edge.

Top module: `dual_chan_irq_unit`

## Requirements
- R1: The status byte places channel A transmitter-ready at bit 0, channel A receive-ready at bit 1, channel B transmitter-ready at bit 4 and channel B receive-ready at bit 5. Each bit shows the level its input had at the most recent rising clock edge.
- R2: Status bits 2, 3, 6 and 7 always read as 0.
- R3: A write with `busWrEn` high at address 0x14 loads the mask from `busWrData` at the next rising edge. Only bits 0, 1, 4 and 5 are stored (same meaning as the status bits), and the other bits are dropped.
- R4: A read with `busRdEn` high at address 0x14 returns the status byte in the same cycle, never the mask.
- R5: `irqOut` is 1 exactly when some bit is 1 in both the status register and the mask register. It is therefore one clock behind the channel inputs and one clock behind a mask write.
- R6: While `rstN` is low at a rising edge, the status and the mask are cleared. Afterwards `irqOut` stays 0 until a mask bit and its matching ready level are both 1.
- R7: A write at any address other than 0x14 leaves the mask unchanged. A read at any other address, and any cycle with `busRdEn` low, return 0 on `busRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 6 | Byte offset of the host access |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, 0 when no status read is taking place |
| chanTxReady | input | 2 | Transmitter-ready level; bit 0 is channel A, bit 1 is channel B |
| chanRxReady | input | 2 | Receive-ready level; bit 0 is channel A, bit 1 is channel B |
| irqOut | output | 1 | Interrupt request level |

## Verification
The bench first raises one ready input at a time. This separates each status bit position and shows whether channel B is wrongly mapped onto channel A or onto the unused bits. Single-bit masks are then paired with matching and non-matching ready levels, which tells a real AND-reduction apart from an OR of the status bits alone, and a mask that covers a different channel. Writes of all ones at the shared offset, followed by reads with every ready input low, expose any path that lets the mask leak into the read data. Writes at nearby offsets and a reset in the middle of the run check the address decode and the clearing. A stretch of random inputs and writes, compared against the model on every clock, covers the remaining timing of the request.

// File: rtl/irq_unit_pkg.sv
`timescale 1ns/1ps
package irq_unit_pkg;

  typedef struct packed {
    logic maskWrite;
    logic statusRead;
  } irqStrobes_t;

endpackage

// File: rtl/irq_unit_ctrl.sv
`timescale 1ns/1ps
module irq_unit_ctrl
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] SHARED_OFFSET = 6'h14
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output irqStrobes_t       strobes
);

  logic offsetHit;

  assign offsetHit = (busAddr == SHARED_OFFSET);

  // One offset, two registers: the direction of the access picks which one.
  always_comb begin
    strobes            = '0;
    strobes.maskWrite  = busWrEn && offsetHit;
    strobes.statusRead = busRdEn && offsetHit;
  end

endmodule

// File: rtl/irq_unit_datapath.sv
`timescale 1ns/1ps
module irq_unit_datapath
  import irq_unit_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CH_STRIDE = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [NUM_CH-1:0] chanTxReady,
  input  logic [NUM_CH-1:0] chanRxReady,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  localparam int TX_POS = 0;
  localparam int RX_POS = 1;

  function automatic logic [DATA_W-1:0] usedBits();
    logic [DATA_W-1:0] v;
    v = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      v[c*CH_STRIDE + TX_POS] = 1'b1;
      v[c*CH_STRIDE + RX_POS] = 1'b1;
    end
    return v;
  endfunction

  localparam logic [DATA_W-1:0] USED_MASK = usedBits();

  logic [DATA_W-1:0] statusNext;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] maskQ;
  logic [1:0]        chanPair [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chanPair[c] = {chanRxReady[c], chanTxReady[c]};
  end

  always_comb begin
    statusNext = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      statusNext[c*CH_STRIDE + TX_POS] = chanPair[c][0];
      statusNext[c*CH_STRIDE + RX_POS] = chanPair[c][1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusNext;
      if (strobes.maskWrite) begin
        maskQ <= busWrData & USED_MASK;
      end
    end
  end

  assign irqOut    = |(statusQ & maskQ);
  assign busRdData = strobes.statusRead ? statusQ : '0;

endmodule

// File: rtl/dual_chan_irq_unit.sv
`timescale 1ns/1ps
module dual_chan_irq_unit
  import irq_unit_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CH_STRIDE = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] SHARED_OFFSET = 6'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic [NUM_CH-1:0] chanTxReady,
  input  logic [NUM_CH-1:0] chanRxReady,
  output logic              irqOut
);

  irqStrobes_t strobes;

  irq_unit_ctrl #(
    .ADDR_W       (ADDR_W),
    .SHARED_OFFSET(SHARED_OFFSET)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strobes(strobes)
  );

  irq_unit_datapath #(
    .NUM_CH   (NUM_CH),
    .CH_STRIDE(CH_STRIDE),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWrData  (busWrData),
    .chanTxReady(chanTxReady),
    .chanRxReady(chanRxReady),
    .busRdData  (busRdData),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/irq_unit_checker.sv
`timescale 1ns/1ps
module irq_unit_checker #(
  parameter int NUM_CH    = 2,
  parameter int CH_STRIDE = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] SHARED_OFFSET = 6'h14
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic [NUM_CH-1:0] chanTxReady,
  input logic [NUM_CH-1:0] chanRxReady,
  input logic              irqOut
);

  function automatic logic [DATA_W-1:0] packLevels(logic [NUM_CH-1:0] tx,
                                                   logic [NUM_CH-1:0] rx);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      v[c*CH_STRIDE]     = tx[c];
      v[c*CH_STRIDE + 1] = rx[c];
    end
    return v;
  endfunction

  localparam logic [DATA_W-1:0] LIVE = packLevels('1, '1);

  logic              inRstQ;
  logic [DATA_W-1:0] shadowMaskQ;

  // Shadow of the mask as seen from the bus side.
  always_ff @(posedge clk) begin
    inRstQ <= !rstN;
    if (!rstN) begin
      shadowMaskQ <= '0;
    end else if (busWrEn && busAddr == SHARED_OFFSET) begin
      shadowMaskQ <= busWrData & LIVE;
    end
  end

  p_status_place_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!inRstQ && busRdEn && busAddr == SHARED_OFFSET) |->
      busRdData == packLevels($past(chanTxReady), $past(chanRxReady)));

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData & ~LIVE) == '0);

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    !inRstQ |->
      irqOut == |(packLevels($past(chanTxReady), $past(chanRxReady)) & shadowMaskQ));

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    inRstQ |-> (!irqOut && busRdData == '0));

  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdEn || busAddr != SHARED_OFFSET) |-> busRdData == '0);

endmodule

bind dual_chan_irq_unit irq_unit_checker #(
  .NUM_CH       (NUM_CH),
  .CH_STRIDE    (CH_STRIDE),
  .DATA_W       (DATA_W),
  .ADDR_W       (ADDR_W),
  .SHARED_OFFSET(SHARED_OFFSET)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .busRdEn    (busRdEn),
  .busRdData  (busRdData),
  .chanTxReady(chanTxReady),
  .chanRxReady(chanRxReady),
  .irqOut     (irqOut)
);

// File: tb/sim_dual_chan_irq_unit.sv
`timescale 1ns/1ps
module sim_dual_chan_irq_unit;

  localparam logic [5:0] OFS = 6'h14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic [1:0] chanTxReady = '0;
  logic [1:0] chanRxReady = '0;
  logic       irqOut;

  int  checks = 0;
  int  failures = 0;
  bit  clockCheckOn = 1'b0;
  bit  finished = 1'b0;

  logic [7:0] modelStatus = '0;
  logic [7:0] modelMask = '0;

  always #4 clk = ~clk;

  dual_chan_irq_unit u0 (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .busRdEn    (busRdEn),
    .busRdData  (busRdData),
    .chanTxReady(chanTxReady),
    .chanRxReady(chanRxReady),
    .irqOut     (irqOut)
  );

  // Behavioural reference: status bits at 0,1 (A) and 4,5 (B), mask keeps 0x33.
  always @(posedge clk) begin
    if (!rstN) begin
      modelStatus <= 8'h00;
      modelMask   <= 8'h00;
    end else begin
      modelStatus <= (chanTxReady[0] ? 8'h01 : 8'h00) | (chanRxReady[0] ? 8'h02 : 8'h00) |
                     (chanTxReady[1] ? 8'h10 : 8'h00) | (chanRxReady[1] ? 8'h20 : 8'h00);
      if (busWrEn && busAddr == OFS) modelMask <= busWrData & 8'h33;
    end
  end

  // Request level compared against the model on every clock (R5).
  always @(negedge clk) begin
    if (clockCheckOn) begin
      checks++;
      if (irqOut !== ((modelStatus & modelMask) != 8'h00)) begin
        failures++;
        $display("FAIL R5 irq level at %0t: actual=%b expected=%b", $time, irqOut,
                 ((modelStatus & modelMask) != 8'h00));
      end
    end
  end

  task automatic checkEq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setLevels(input logic [1:0] tx, input logic [1:0] rx);
    @(negedge clk);
    chanTxReady = tx;
    chanRxReady = rx;
  endtask

  task automatic writeBus(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1;
    checkEq(tag, busRdData, exp);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic irqCheck(input logic exp, input string tag);
    @(negedge clk);
    #1;
    checkEq(tag, {7'b0, irqOut}, {7'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    clockCheckOn = 1'b1;
    rstN = 1'b1;
    // R6: cleared state straight after reset
    readCheck(OFS, 8'h00, "R6 status after reset");
    irqCheck(1'b0, "R6 irq after reset");

    // R1: one level at a time
    setLevels(2'b01, 2'b00); readCheck(OFS, 8'h01, "R1 tx A at bit0");
    setLevels(2'b00, 2'b01); readCheck(OFS, 8'h02, "R1 rx A at bit1");
    setLevels(2'b10, 2'b00); readCheck(OFS, 8'h10, "R1 tx B at bit4");
    setLevels(2'b00, 2'b10); readCheck(OFS, 8'h20, "R1 rx B at bit5");
    // R2: all ready, unused bits stay 0
    setLevels(2'b11, 2'b11); readCheck(OFS, 8'h33, "R2 unused bits zero");
    // R6: mask resets to 0, so no request with everything ready
    irqCheck(1'b0, "R6 mask cleared by reset");

    // R3/R4: load mask with all ones, status read must not show it
    setLevels(2'b00, 2'b00);
    writeBus(OFS, 8'hFF);
    readCheck(OFS, 8'h00, "R4 read returns status not mask");
    irqCheck(1'b0, "R5 mask set but nothing ready");
    setLevels(2'b00, 2'b10);
    irqCheck(1'b1, "R3 mask bit5 stored");

    // R5: single-bit mask on tx B
    writeBus(OFS, 8'h10);
    setLevels(2'b01, 2'b11);
    irqCheck(1'b0, "R5 tx B masked-in, only others ready");
    setLevels(2'b10, 2'b00);
    irqCheck(1'b1, "R5 tx B ready and enabled");
    // R3: bits outside 0,1,4,5 are dropped
    writeBus(OFS, 8'hCC);
    setLevels(2'b11, 2'b11);
    irqCheck(1'b0, "R3 unused mask bits dropped");

    // R7: nearby offsets do not touch the mask, reads elsewhere give 0
    writeBus(6'h10, 8'h33);
    writeBus(6'h34, 8'h33);
    irqCheck(1'b0, "R7 write elsewhere ignored");
    readCheck(6'h34, 8'h00, "R7 read elsewhere zero");
    readCheck(6'h15, 8'h00, "R7 read neighbour zero");
    @(negedge clk); #1;
    checkEq("R7 idle read data zero", busRdData, 8'h00);

    // R5: random inputs and writes, checked every clock
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      chanTxReady = 2'($urandom);
      chanRxReady = 2'($urandom);
      busWrEn     = ($urandom % 4) == 0;
      busAddr     = ($urandom % 2) ? OFS : 6'($urandom);
      busWrData   = 8'($urandom);
    end
    @(negedge clk); busWrEn = 1'b0;
    readCheck(OFS, modelStatus, "R1 status after random run");

    // R6: reset in mid-run with mask and levels set
    writeBus(OFS, 8'h33);
    setLevels(2'b11, 2'b11);
    irqCheck(1'b1, "R5 full mask all ready");
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    checkEq("R6 status cleared by reset", busRdData, 8'h00);
    checkEq("R6 irq cleared by reset", {7'b0, irqOut}, 8'h00);
    irqCheck(1'b0, "R6 mask cleared after mid-run reset");
    readCheck(OFS, 8'h33, "R1 status resumes after reset");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule